// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects a set of level-sensitive interrupt request lines and, every clock, works out which pending request should be serviced next. Software gives each line four attributes: a priority level, a register-set number for the handler, a non-maskable flag and an enable bit. Among the lines that are pending, enabled and at a nonzero level, the one with the highest level wins. The block then forms that line's handler address from a programmable vector base and a power-of-two spacing between vectors.

The chosen request leaves the block as one record on a registered valid/data output: level, register set, non-maskable flag and handler address. A second record of the same shape may arrive from an upstream controller. The block weighs it against the best local request and forwards whichever is higher, so controllers can be chained to serve more lines than one instance holds. The configuration registers are reached through a simple word-addressed write port with a combinational read port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and until the first clock after its synchronised release, out_valid is 0, every enable bit is 0 and every line config word reads 0.
- R2: The config word of line i sits at word address i (byte offset 4*i). Bits [5:0] hold the level, bits [11:6] the register set and bit [12] the non-maskable flag. Bits [31:13] are ignored on write and read as 0.
- R3: A write to word 32 sets the enable bits given as ones in the data. A write to word 33 clears them. A read of either word returns the enable mask. A line whose enable is 0 is never selected.
- R4: Word 34 reads the raw request lines, whether or not they are enabled.
- R5: A line whose level is 0 is never selected, even when it is pending and enabled.
- R6: Among the candidate lines, the highest level wins. On equal levels the lower line index wins.
- R7: The handler address equals the vector base (word 35) plus the line index times the spacing. The spacing is 16 << code, where code is bits [2:0] of word 36. Codes above 5 give 512.
- R8: The output record carries the winning line's register set and non-maskable flag.
- R9: An upstream record counts as a candidate when up_valid is 1 and its level is nonzero. It wins only when its level is strictly higher than the best local level, and then it is forwarded unchanged, handler address included.
- R10: out_valid is 1 exactly when some candidate exists. The record is registered, so it reflects the inputs and configuration present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| irq | input | NUM_LINES | Level-sensitive request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the addressed word |
| up_valid | input | 1 | Upstream record valid |
| up_level | input | 6 | Upstream record level |
| up_rset | input | 6 | Upstream record register set |
| up_nmi | input | 1 | Upstream record non-maskable flag |
| up_addr | input | 32 | Upstream record handler address |
| out_valid | output | 1 | Output record valid |
| out_level | output | 6 | Selected level |
| out_rset | output | 6 | Selected register set |
| out_nmi | output | 1 | Selected non-maskable flag |
| out_addr | output | 32 | Selected handler address |

## Verification
The hardest cases to reach are the ties: two enabled local lines at the same level, and an upstream record whose level equals the best local level. In both, only the tie-break rule settles the winner. The bench sets up eight lines that include two equal-level pairs, one line at level 0 and one disabled line. It then applies every one of the 256 request patterns against several upstream levels: absent, zero, equal to a local tie level, equal to the top local level, and above it. Every tie therefore arises many times, and the bench also sweeps all eight spacing codes over every single-line request.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int LVL_W   = 6;
  localparam int RS_W    = 6;
  localparam int CFG_AW  = 6;
  localparam int DATA_W  = 32;
  localparam int VADDR_W = 32;
  localparam int MAX_SHIFT_CODE = 5;
  localparam int BASE_SHIFT     = 4;

  localparam logic [CFG_AW-1:0] W_EN_SET  = 6'd32;
  localparam logic [CFG_AW-1:0] W_EN_CLR  = 6'd33;
  localparam logic [CFG_AW-1:0] W_PENDING = 6'd34;
  localparam logic [CFG_AW-1:0] W_VBASE   = 6'd35;
  localparam logic [CFG_AW-1:0] W_SPACING = 6'd36;

  typedef struct packed {
    logic               valid;
    logic [LVL_W-1:0]   level;
    logic [RS_W-1:0]    rset;
    logic               nmi;
    logic [VADDR_W-1:0] addr;
  } irq_rec_t;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [CFG_AW-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [NUM_LINES-1:0]            irq,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_LINES-1:0][LVL_W-1:0] line_lvl,
  output logic [NUM_LINES-1:0][RS_W-1:0]  line_rs,
  output logic [NUM_LINES-1:0]            line_nmi,
  output logic [NUM_LINES-1:0]            enable,
  output logic [VADDR_W-1:0]              vbase,
  output logic [2:0]                      scode
);
  logic [NUM_LINES-1:0] en_d;
  logic                 en_ce;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic wr_line;
    assign wr_line = we && (addr == CFG_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_lvl[g] <= '0;
        line_rs[g]  <= '0;
        line_nmi[g] <= 1'b0;
      end else if (wr_line) begin
        line_lvl[g] <= wdata[LVL_W-1:0];
        line_rs[g]  <= wdata[LVL_W+RS_W-1:LVL_W];
        line_nmi[g] <= wdata[LVL_W+RS_W];
      end
    end
  end

  always_comb begin
    en_ce = we && (addr == W_EN_SET || addr == W_EN_CLR);
    if (addr == W_EN_SET) en_d = enable | wdata[NUM_LINES-1:0];
    else                  en_d = enable & ~wdata[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      vbase  <= '0;
      scode  <= '0;
    end else begin
      if (en_ce) enable <= en_d;
      if (we && addr == W_VBASE) vbase <= wdata;
      if (we && addr == W_SPACING) scode <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (addr == CFG_AW'(i))
        rdata = DATA_W'({line_nmi[i], line_rs[i], line_lvl[i]});
    end
    case (addr)
      W_EN_SET, W_EN_CLR: rdata = DATA_W'(enable);
      W_PENDING:          rdata = DATA_W'(irq);
      W_VBASE:            rdata = vbase;
      W_SPACING:          rdata = DATA_W'(scode);
      default: ;
    endcase
  end
endmodule

// File: rtl/irqv_select.sv
module irqv_select
  import irqv_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0]            irq,
  input  logic [NUM_LINES-1:0]            enable,
  input  logic [NUM_LINES-1:0][LVL_W-1:0] line_lvl,
  input  logic [NUM_LINES-1:0][RS_W-1:0]  line_rs,
  input  logic [NUM_LINES-1:0]            line_nmi,
  input  logic [VADDR_W-1:0]              vbase,
  input  logic [2:0]                      scode,
  input  irq_rec_t                        up_rec,
  output irq_rec_t                        win
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic [2:0]       shift;
  logic [VADDR_W-1:0] local_addr;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irq[i] && enable[i] && (line_lvl[i] > best_lvl)) begin
        best_lvl = line_lvl[i];
        best_idx = IDX_W'(i);
      end
    end
    shift = (scode > 3'(MAX_SHIFT_CODE)) ? 3'(MAX_SHIFT_CODE) : scode;
    local_addr = vbase + (VADDR_W'(best_idx) << (BASE_SHIFT + int'(shift)));

    win = '0;
    if (up_rec.valid && (up_rec.level > best_lvl)) begin
      win = up_rec;
    end else if (best_lvl != '0) begin
      win.valid = 1'b1;
      win.level = best_lvl;
      win.rset  = line_rs[best_idx];
      win.nmi   = line_nmi[best_idx];
      win.addr  = local_addr;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq,
  input  logic                 cfg_we,
  input  logic [5:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 up_valid,
  input  logic [5:0]           up_level,
  input  logic [5:0]           up_rset,
  input  logic                 up_nmi,
  input  logic [31:0]          up_addr,
  output logic                 out_valid,
  output logic [5:0]           out_level,
  output logic [5:0]           out_rset,
  output logic                 out_nmi,
  output logic [31:0]          out_addr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_LINES-1:0][LVL_W-1:0] line_lvl;
  logic [NUM_LINES-1:0][RS_W-1:0]  line_rs;
  logic [NUM_LINES-1:0]            line_nmi;
  logic [NUM_LINES-1:0]            enable;
  logic [VADDR_W-1:0]              vbase;
  logic [2:0]                      scode;
  irq_rec_t                        up_rec, rec_d, rec_q;

  irqv_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .irq(irq), .rdata(cfg_rdata),
    .line_lvl(line_lvl), .line_rs(line_rs), .line_nmi(line_nmi),
    .enable(enable), .vbase(vbase), .scode(scode)
  );

  always_comb begin
    up_rec.valid = up_valid && (up_level != '0);
    up_rec.level = up_level;
    up_rec.rset  = up_rset;
    up_rec.nmi   = up_nmi;
    up_rec.addr  = up_addr;
  end

  irqv_select #(.NUM_LINES(NUM_LINES)) u_sel (
    .irq(irq), .enable(enable), .line_lvl(line_lvl), .line_rs(line_rs),
    .line_nmi(line_nmi), .vbase(vbase), .scode(scode),
    .up_rec(up_rec), .win(rec_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rec_q <= '0;
    else             rec_q <= rec_d;
  end

  assign out_valid = rec_q.valid;
  assign out_level = rec_q.level;
  assign out_rset  = rec_q.rset;
  assign out_nmi   = rec_q.nmi;
  assign out_addr  = rec_q.addr;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq,
  input logic                 up_valid,
  input logic [5:0]           up_level,
  input logic [31:0]          up_addr,
  input logic                 out_valid,
  input logic [5:0]           out_level,
  input logic [31:0]          out_addr
);
  assert_no_zero_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_level != 6'd0));

  assert_idle_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == '0 && !up_valid) |=> !out_valid);

  assert_upstream_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_level != 6'd0) |=> (out_valid && out_level >= $past(up_level)));

  assert_upstream_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == '0 && up_valid && up_level != 6'd0) |=>
      (out_level == $past(up_level) && out_addr == $past(up_addr)));
endmodule

bind irq_vector_ctrl irqv_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq(irq), .up_valid(up_valid),
  .up_level(up_level), .up_addr(up_addr), .out_valid(out_valid),
  .out_level(out_level), .out_addr(out_addr)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] irq;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        up_valid, up_nmi;
  logic [5:0]  up_level, up_rset;
  logic [31:0] up_addr;
  logic        out_valid, out_nmi;
  logic [5:0]  out_level, out_rset;
  logic [31:0] out_addr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int lvl_m [N] = '{3, 5, 5, 0, 7, 2, 7, 1};
  logic [7:0] en_m;
  logic [31:0] base_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .up_valid(up_valid),
    .up_level(up_level), .up_rset(up_rset), .up_nmi(up_nmi), .up_addr(up_addr),
    .out_valid(out_valid), .out_level(out_level), .out_rset(out_rset),
    .out_nmi(out_nmi), .out_addr(out_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic apply_and_check(input logic [N-1:0] r, input logic uv, input int ul,
                                 input logic [2:0] code);
    int best, bidx, sh;
    logic ev, enmi;
    logic [5:0] el, ers;
    logic [31:0] ea;
    @(negedge clk);
    irq = r; up_valid = uv; up_level = 6'(ul); up_rset = 6'd33; up_nmi = 1'b1;
    up_addr = 32'hCAFE_0000 + 32'(ul);
    best = 0; bidx = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && en_m[i] && lvl_m[i] > best) begin best = lvl_m[i]; bidx = i; end
    sh = (code > 5) ? 5 : int'(code);
    if (uv && ul > best) begin
      ev = 1; el = 6'(ul); ers = 6'd33; enmi = 1; ea = up_addr;
    end else if (best != 0) begin
      ev = 1; el = 6'(best); ers = 6'(bidx + 10); enmi = bidx[0];
      ea = base_m + 32'(bidx * (16 << sh));
    end else begin
      ev = 0; el = 0; ers = 0; enmi = 0; ea = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check("R10 valid", {31'b0, out_valid}, {31'b0, ev});
    if (ev) begin
      check("R6 level", {26'b0, out_level}, {26'b0, el});
      check("R8 rset", {26'b0, out_rset}, {26'b0, ers});
      check("R8 nmi", {31'b0, out_nmi}, {31'b0, enmi});
      check("R7 addr", out_addr, ea);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    up_valid = 0; up_level = '0; up_rset = '0; up_nmi = 0; up_addr = '0;
    en_m = '0; base_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check("R1 valid", {31'b0, out_valid}, 32'd0);
    rd_check("R1 enable", 6'd32, 32'd0);
    rd_check("R1 line cfg", 6'd5, 32'd0);

    // R2 config words, upper bits ignored
    for (int i = 0; i < N; i++)
      wr(6'(i), 32'hFFFF_E000 | (32'(i[0]) << 12) | (32'(i + 10) << 6) | 32'(lvl_m[i]));
    for (int i = 0; i < N; i++)
      rd_check("R2 readback", 6'(i), (32'(i[0]) << 12) | (32'(i + 10) << 6) | 32'(lvl_m[i]));

    // R4 raw pending, R3 disabled lines ignored
    @(negedge clk); irq = 8'hA5;
    rd_check("R4 pending", 6'd34, 32'h0000_00A5);
    @(posedge clk); @(negedge clk);
    check("R3 all disabled", {31'b0, out_valid}, 32'd0);

    // R3 enable set and clear
    wr(6'd32, 32'h0000_000F);
    wr(6'd32, 32'h0000_00F0);
    rd_check("R3 set", 6'd32, 32'h0000_00FF);
    wr(6'd33, 32'h0000_0080);
    rd_check("R3 clear", 6'd33, 32'h0000_007F);
    en_m = 8'h7F;

    // R5 level-0 line alone
    @(negedge clk); irq = 8'h08;
    @(posedge clk); @(negedge clk);
    check("R5 level zero", {31'b0, out_valid}, 32'd0);

    // R10 latency: output unchanged before the edge
    @(negedge clk); irq = 8'h10;
    #1 check("R10 before edge", {31'b0, out_valid}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R10 after edge", {26'b0, out_level}, 32'd7);

    // R7 spacing codes over single lines
    base_m = 32'h1000_0040;
    wr(6'd35, base_m);
    for (int c = 0; c < 8; c++) begin
      wr(6'd36, 32'(c));
      for (int i = 0; i < N; i++) apply_and_check(8'(1 << i), 1'b0, 0, 3'(c));
    end

    // R6 R8 R9 exhaustive patterns against upstream levels
    wr(6'd36, 32'd2);
    for (int u = 0; u < 6; u++) begin
      for (int p = 0; p < 256; p++) begin
        case (u)
          0: apply_and_check(8'(p), 1'b0, 9, 3'd2);
          1: apply_and_check(8'(p), 1'b1, 0, 3'd2);
          2: apply_and_check(8'(p), 1'b1, 5, 3'd2);
          3: apply_and_check(8'(p), 1'b1, 7, 3'd2);
          4: apply_and_check(8'(p), 1'b1, 8, 3'd2);
          default: apply_and_check(8'(p), 1'b1, 2, 3'd2);
        endcase
      end
    end

    // R9 upstream passthrough with no local request
    apply_and_check(8'h00, 1'b1, 4, 3'd2);
    check("R9 passthrough addr", out_addr, 32'hCAFE_0004);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule